// File: doc/BRIEF.md
# Two-Wire Byte-Data Host Controller

This block is the master side of a two-wire management bus. It runs single byte-data transactions: one data byte is written to a numbered location in a slave, or read back from it. Software programs the transaction through a small 8-bit register window. It writes the slave address with a direction bit, a command byte (the location in the slave) and, for writes, the data byte. It then writes the control register with the protocol field set to byte-data and the start bit set. The controller produces the whole bus sequence from a quarter-bit prescaler, then reports the result in a status register whose flags are cleared by writing ones.

A write sends START, the address with a 0 direction bit, the command byte, the data byte and STOP. A read sends START, the address with direction 0 and the command byte. It then sends a repeated START and the address with direction 1, receives one byte, answers it with a NACK and ends with STOP. Both lines are open-drain: the block only pulls a line low or releases it, and an external pull-up makes it high.

Register window (3-bit offset): 0 status, 1 prescaler, 2 control, 3 command, 4 target address, 5 data.

Top module: `smb_host`

## Requirements
- R1: After reset the status (offset 0) and control (offset 2) registers read 0x00, `irq` is low and both `scl_oe` and `sda_oe` are low (bus released).
- R2: With target address bit 0 = 0, a start produces START, {addr[7:1],0}, the command byte, the data byte (MSB first, each followed by a slave ACK slot) and STOP. On completion status bit 1 (done) is set.
- R3: With target address bit 0 = 1, a start produces START, {addr[7:1],0}, the command, a repeated START, {addr[7:1],1}, a received byte, a master NACK and STOP. The received byte then reads back at offset 5.
- R4: Status bit 0 (busy) reads 1 from the cycle after an accepted start until the STOP condition has finished, then reads 0.
- R5: Writing status clears each of bits 1, 2 and 6 that is written as 1 and leaves each bit written as 0 unchanged.
- R6: A NACK from the slave in any byte's acknowledge slot ends the transfer with STOP, sets status bit 2 (device error), leaves done at 0 and clears busy.
- R7: Control bit 6 (start) always reads 0. Control bit 0 (interrupt enable) and bits 4:2 (protocol) read back as written.
- R8: A start is accepted only when bits 4:2 of the same control write equal 2 (byte-data) and the block is idle. Otherwise busy stays 0 and the bus stays released.
- R9: `irq` is high exactly when control bit 0 is set and status bit 1 or bit 2 is set.
- R10: Status bit 6 (in-use) reads 0 on the first status read after it was cleared. That read sets it, and later reads return 1 until it is cleared by writing 1.
- R11: Within address, command and data bytes SDA changes only while SCL is low. Across a whole transaction the slave sees one START for a write, two for a read, and exactly one STOP.
- R12: The prescaler (offset 1, value P) makes each quarter-bit P+1 clock cycles long, so SCL stays released for 2*(P+1) cycles in each bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, zero when `reg_rd` is low |
| irq | output | 1 | Completion interrupt, level |
| sda_in | input | 1 | Sampled SDA line |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The main function is tried with a write and with reads of 0xC3 and 0x01. These data values show whether the byte order is right, whether any bit is lost in the shift, and whether data is taken from the correct SCL phase. A slave that refuses its address and another that refuses the data byte separate the error path from the done path. Two prescaler values check that the SCL high time scales with the setting and is not fixed. A start with the wrong protocol value, interrupt enable set and cleared, and in-use read sequences check the register rules apart from the bus traffic.

// File: rtl/smb_pkg.sv
package smb_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] OFS_STAT = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_DIV  = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_CTL  = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_CMD  = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_TXA  = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_DAT  = 3'd5;

    localparam logic [2:0] PROTO_BYTE_DATA = 3'd2;

    typedef enum logic [3:0] {
        ST_IDLE, ST_START, ST_ADDRW, ST_CMD, ST_DATAW,
        ST_RSTART, ST_ADDRR, ST_DATAR, ST_STOP
    } seq_st_e;

    typedef struct packed {
        seq_st_e           st;
        logic [1:0]        ph;
        logic [3:0]        bitn;
        logic [DATA_W-1:0] sh;
        logic [DATA_W-1:0] rx;
        logic              nack;
        logic              scl_low;
        logic              sda_low;
    } seq_t;

    typedef struct packed {
        logic [DATA_W-1:0] div;
        logic [DATA_W-1:0] cmd;
        logic [DATA_W-1:0] txa;
        logic [DATA_W-1:0] dat;
        logic [2:0]        proto;
        logic              ien;
        logic              done;
        logic              err;
        logic              inuse;
    } regs_t;
endpackage

// File: rtl/smb_presc.sv
module smb_presc #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] limit,
    output logic             tick
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == limit);
        cnt_d = cnt_q;
        if (!en || tick) cnt_d = '0;
        else             cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/smb_seq.sv
module smb_seq
    import smb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              tick,
    input  logic              rd_mode,
    input  logic [6:0]        dev,
    input  logic [DATA_W-1:0] cmd,
    input  logic [DATA_W-1:0] wbyte,
    input  logic              sda_in,
    output logic              busy,
    output logic              fin,
    output logic              nack,
    output logic [DATA_W-1:0] rx,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              in_byte
);
    seq_t d, q;

    function automatic seq_st_e follow(seq_st_e s, logic rd);
        case (s)
            ST_ADDRW: follow = ST_CMD;
            ST_CMD:   follow = rd ? ST_RSTART : ST_DATAW;
            ST_ADDRR: follow = ST_DATAR;
            default:  follow = ST_STOP;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] load(seq_st_e s, logic [6:0] a,
                                               logic [DATA_W-1:0] c,
                                               logic [DATA_W-1:0] w);
        case (s)
            ST_ADDRW: load = {a, 1'b0};
            ST_CMD:   load = c;
            ST_DATAW: load = w;
            ST_ADDRR: load = {a, 1'b1};
            default:  load = '0;
        endcase
    endfunction

    always_comb begin
        seq_st_e nxt;
        d   = q;
        fin = 1'b0;
        nxt = ST_STOP;
        if (q.st == ST_IDLE) begin
            d.scl_low = 1'b0;
            d.sda_low = 1'b0;
            if (go) begin
                d.st   = ST_START;
                d.ph   = 2'd0;
                d.nack = 1'b0;
            end
        end else if (tick) begin
            d.ph = q.ph + 2'd1;
            case (q.st)
                ST_START: begin
                    if (q.ph == 2'd0) d.sda_low = 1'b1;
                    if (q.ph == 2'd1) d.scl_low = 1'b1;
                    if (q.ph == 2'd3) begin
                        d.st   = ST_ADDRW;
                        d.bitn = '0;
                        d.sh   = load(ST_ADDRW, dev, cmd, wbyte);
                    end
                end
                ST_RSTART: begin
                    case (q.ph)
                        2'd0: d.sda_low = 1'b0;
                        2'd1: d.scl_low = 1'b0;
                        2'd2: d.sda_low = 1'b1;
                        default: begin
                            d.scl_low = 1'b1;
                            d.st      = ST_ADDRR;
                            d.bitn    = '0;
                            d.sh      = load(ST_ADDRR, dev, cmd, wbyte);
                        end
                    endcase
                end
                ST_STOP: begin
                    case (q.ph)
                        2'd0: d.sda_low = 1'b1;
                        2'd1: d.scl_low = 1'b0;
                        2'd2: d.sda_low = 1'b0;
                        default: begin
                            d.st = ST_IDLE;
                            fin  = 1'b1;
                        end
                    endcase
                end
                default: begin
                    case (q.ph)
                        2'd0: begin
                            d.scl_low = 1'b1;
                            d.sda_low = (q.st != ST_DATAR && q.bitn < 4'd8) ? ~q.sh[DATA_W-1] : 1'b0;
                        end
                        2'd1: d.scl_low = 1'b0;
                        2'd2: begin
                            if (q.st == ST_DATAR && q.bitn < 4'd8) d.rx = {q.rx[DATA_W-2:0], sda_in};
                            if (q.st != ST_DATAR && q.bitn == 4'd8 && sda_in) d.nack = 1'b1;
                        end
                        default: begin
                            d.scl_low = 1'b1;
                            if (q.bitn != 4'd8) begin
                                d.sh   = q.sh << 1;
                                d.bitn = q.bitn + 4'd1;
                            end else begin
                                nxt    = q.nack ? ST_STOP : follow(q.st, rd_mode);
                                d.st   = nxt;
                                d.bitn = '0;
                                d.sh   = load(nxt, dev, cmd, wbyte);
                            end
                        end
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign busy    = (q.st != ST_IDLE);
    assign nack    = q.nack;
    assign rx      = q.rx;
    assign scl_oe  = q.scl_low;
    assign sda_oe  = q.sda_low;
    assign in_byte = (q.st == ST_ADDRW) || (q.st == ST_CMD) || (q.st == ST_DATAW) ||
                     (q.st == ST_ADDRR) || (q.st == ST_DATAR);
endmodule

// File: rtl/smb_host.sv
module smb_host
    import smb_pkg::*;
#(
    parameter logic [DATA_W-1:0] DIV_RESET = 8'd4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe
);
    regs_t             d, q;
    logic              go, tick, seq_busy, seq_fin, seq_nack, seq_in_byte;
    logic              st_done, st_err;
    logic [DATA_W-1:0] seq_rx;

    smb_presc #(.CNT_W(DATA_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .en(seq_busy), .limit(q.div), .tick(tick)
    );

    smb_seq u_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .tick(tick), .rd_mode(q.txa[0]),
        .dev(q.txa[7:1]), .cmd(q.cmd), .wbyte(q.dat), .sda_in(sda_in),
        .busy(seq_busy), .fin(seq_fin), .nack(seq_nack), .rx(seq_rx),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .in_byte(seq_in_byte)
    );

    always_comb begin
        d  = q;
        go = 1'b0;
        if (reg_wr) begin
            case (reg_addr)
                OFS_STAT: begin
                    if (reg_wdata[1]) d.done  = 1'b0;
                    if (reg_wdata[2]) d.err   = 1'b0;
                    if (reg_wdata[6]) d.inuse = 1'b0;
                end
                OFS_DIV: if (!seq_busy) d.div = reg_wdata;
                OFS_CTL: begin
                    d.ien   = reg_wdata[0];
                    d.proto = reg_wdata[4:2];
                    go      = reg_wdata[6] && (reg_wdata[4:2] == PROTO_BYTE_DATA) && !seq_busy;
                end
                OFS_CMD: if (!seq_busy) d.cmd = reg_wdata;
                OFS_TXA: if (!seq_busy) d.txa = reg_wdata;
                OFS_DAT: if (!seq_busy) d.dat = reg_wdata;
                default: ;
            endcase
        end
        if (reg_rd && !reg_wr && reg_addr == OFS_STAT && !q.inuse) d.inuse = 1'b1;
        if (seq_fin) begin
            if (seq_nack) d.err = 1'b1;
            else begin
                d.done = 1'b1;
                if (q.txa[0]) d.dat = seq_rx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{div: DIV_RESET, default: '0};
        else        q <= d;
    end

    assign st_done = q.done;
    assign st_err  = q.err;
    assign irq     = q.ien && (st_done || st_err);

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (reg_addr)
                OFS_STAT: reg_rdata = {1'b0, q.inuse, 3'b000, st_err, st_done, seq_busy};
                OFS_DIV:  reg_rdata = q.div;
                OFS_CTL:  reg_rdata = {3'b000, q.proto, 1'b0, q.ien};
                OFS_CMD:  reg_rdata = q.cmd;
                OFS_TXA:  reg_rdata = q.txa;
                OFS_DAT:  reg_rdata = q.dat;
                default:  reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/smb_host_chk.sv
module smb_host_chk
    import smb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              irq,
    input logic              scl_oe,
    input logic              sda_oe,
    input logic              busy,
    input logic              in_byte,
    input logic              done,
    input logic              err
);
    a_r4_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == OFS_CTL && reg_wdata[6] && reg_wdata[4:2] == PROTO_BYTE_DATA && !busy |=> busy);

    a_r8_bad_proto_idle: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == OFS_CTL && reg_wdata[4:2] != PROTO_BYTE_DATA && !busy |=> !busy);

    a_r2_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $fell(busy));

    a_r6_err_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $fell(busy));

    a_r9_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) && !$past(reg_wr) |-> $fell(busy));

    a_r11_sda_stable: assert property (@(posedge clk) disable iff (!rst_n)
        in_byte && !scl_oe && $past(!scl_oe) |-> $stable(sda_oe));

    a_r7_start_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd && reg_addr == OFS_CTL |-> !reg_rdata[6]);

    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !scl_oe && !sda_oe);
endmodule

bind smb_host smb_host_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .busy(seq_busy), .in_byte(seq_in_byte), .done(st_done), .err(st_err)
);

// File: tb/smb_host_bench.sv
module smb_host_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq, scl_oe, sda_oe;
    logic       s_drv = 1'b0;
    wire        scl_w = ~scl_oe;
    wire        sda_w = ~(sda_oe | s_drv);

    int checks = 0, errors = 0, cyc = 0;
    bit finished = 0;

    smb_host u_smb_host (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .sda_in(sda_w),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    always #5 clk = ~clk;

    // behavioural slave at 7-bit address 0x50
    localparam logic [6:0] SLV = 7'h50;
    logic [7:0] s_mem [256];
    logic [7:0] s_sh = '0, s_tsh = '0, s_ptr = '0;
    int  s_cnt = 0, s_idx = 0, nack_at = -1, n_start = 0, n_stop = 0;
    bit  s_act = 0, s_tx = 0, s_rdp = 0, s_mack = 0;

    always @(negedge sda_w) if (rst_n && scl_w === 1'b1) begin
        n_start++; s_act = 1; s_cnt = 0; s_idx = 0; s_tx = 0; s_rdp = 0;
    end
    always @(posedge sda_w) if (rst_n && scl_w === 1'b1) begin
        n_stop++; s_act = 0;
    end
    always @(posedge scl_w) if (s_act) begin
        if (s_cnt < 8 && !s_tx) s_sh = {s_sh[6:0], sda_w};
        if (s_cnt == 8 && s_tx) s_mack = (sda_w == 1'b0);
        s_cnt++;
    end
    always @(negedge scl_w) if (s_act) begin
        if (s_cnt == 8 && !s_tx) begin
            bit ok;
            ok = 1;
            if (s_idx == 0) begin
                ok = (s_sh[7:1] == SLV);
                if (ok && s_sh[0]) s_rdp = 1;
            end else if (s_idx == 1) s_ptr = s_sh;
            else if (s_idx == 2) s_mem[s_ptr] = s_sh;
            if (nack_at == s_idx) ok = 0;
            s_drv = ok;
            if (!ok) s_act = 0;
        end else if (s_cnt == 8 && s_tx) begin
            s_drv = 0;
        end else if (s_cnt == 9) begin
            s_drv = 0; s_cnt = 0; s_idx++;
            if (s_rdp) begin s_tx = 1; s_rdp = 0; end
            else if (s_tx && !s_mack) begin s_tx = 0; s_act = 0; end
            if (s_tx) begin s_tsh = s_mem[s_ptr]; s_drv = ~s_tsh[7]; end
        end else if (s_tx && s_cnt >= 1 && s_cnt <= 7) begin
            s_drv = ~s_tsh[7 - s_cnt];
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk); reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 v = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic wait_idle(output logic [7:0] st);
        int n = 0;
        do begin rd(3'd0, st); n++; end while (st[0] && n < 20000);
        if (n >= 20000) chk(0, "R4 busy never cleared", st, 0);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(3'd0, v); chk(v == 8'h00, "R1 status after reset", v, 0);
        rd(3'd2, v); chk(v == 8'h00, "R1 control after reset", v, 0);
        chk({irq, scl_oe, sda_oe} == 3'b000, "R1 irq/bus after reset", {irq, scl_oe, sda_oe}, 0);
        wr(3'd0, 8'hFF);
    endtask

    task automatic t_write;
        logic [7:0] v;
        int s0, p0;
        wr(3'd1, 8'd1); wr(3'd0, 8'hFF);
        wr(3'd4, 8'hA0); wr(3'd3, 8'h12); wr(3'd5, 8'h5A);
        s0 = n_start; p0 = n_stop;
        wr(3'd2, 8'h48);
        rd(3'd0, v); chk(v[0] == 1'b1, "R4 busy after start", v[0], 1);
        wait_idle(v);
        chk((v & 8'h07) == 8'h02, "R2 write done status", v & 8'h07, 2);
        chk(s_mem[8'h12] == 8'h5A, "R2 slave received byte", s_mem[8'h12], 8'h5A);
        chk(n_start - s0 == 1 && n_stop - p0 == 1, "R11 write start/stop count", (n_start - s0) * 16 + (n_stop - p0), 8'h11);
        rd(3'd2, v); chk(v == 8'h08, "R7 control readback", v, 8'h08);
        wr(3'd0, 8'h00); rd(3'd0, v); chk(v[1] == 1'b1, "R5 write 0 keeps done", v[1], 1);
        wr(3'd0, 8'h02); rd(3'd0, v); chk(v[1] == 1'b0, "R5 write 1 clears done", v[1], 0);
    endtask

    task automatic t_read(input logic [7:0] loc, input logic [7:0] val);
        logic [7:0] v;
        int s0, p0;
        s_mem[loc] = val;
        wr(3'd0, 8'hFF);
        wr(3'd4, 8'hA1); wr(3'd3, loc); wr(3'd5, 8'h00);
        s0 = n_start; p0 = n_stop;
        wr(3'd2, 8'h48);
        wait_idle(v);
        chk((v & 8'h07) == 8'h02, "R3 read done status", v & 8'h07, 2);
        rd(3'd5, v); chk(v == val, "R3 read data", v, val);
        chk(n_start - s0 == 2 && n_stop - p0 == 1, "R11 read start/stop count", (n_start - s0) * 16 + (n_stop - p0), 8'h21);
    endtask

    task automatic t_nack(input logic [7:0] txa, input int where);
        logic [7:0] v;
        wr(3'd0, 8'hFF);
        nack_at = where;
        wr(3'd4, txa); wr(3'd3, 8'h20); wr(3'd5, 8'h77);
        wr(3'd2, 8'h48);
        wait_idle(v);
        nack_at = -1;
        chk((v & 8'h07) == 8'h04, "R6 nack error status", v & 8'h07, 4);
        chk({scl_oe, sda_oe} == 2'b00, "R6 bus released after nack", {scl_oe, sda_oe}, 0);
    endtask

    task automatic t_irq;
        logic [7:0] v;
        wr(3'd0, 8'hFF); wr(3'd2, 8'h01);
        chk(irq == 1'b0, "R9 irq low with no flag", irq, 0);
        wr(3'd4, 8'hA0); wr(3'd2, 8'h49);
        wait_idle(v);
        chk(irq == 1'b1, "R9 irq after done", irq, 1);
        wr(3'd0, 8'h06);
        chk(irq == 1'b0, "R9 irq after clear", irq, 0);
        wr(3'd2, 8'h00);
    endtask

    task automatic t_badproto;
        logic [7:0] v;
        bit seen = 0;
        wr(3'd0, 8'hFF);
        wr(3'd2, 8'h44);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk); if (scl_oe || sda_oe) seen = 1;
        end
        chk(!seen, "R8 bus stays released", seen, 0);
        rd(3'd0, v); chk((v & 8'h07) == 8'h00, "R8 no transaction", v & 8'h07, 0);
    endtask

    task automatic t_inuse;
        logic [7:0] v;
        wr(3'd0, 8'h40);
        rd(3'd0, v); chk(v[6] == 1'b0, "R10 first read in-use", v[6], 0);
        rd(3'd0, v); chk(v[6] == 1'b1, "R10 second read in-use", v[6], 1);
        wr(3'd0, 8'h40);
        rd(3'd0, v); chk(v[6] == 1'b0, "R10 in-use cleared", v[6], 0);
    endtask

    task automatic t_presc(input logic [7:0] p);
        logic [7:0] v;
        int n = 0, guard = 0;
        wr(3'd1, p); wr(3'd0, 8'hFF); wr(3'd4, 8'hA0);
        wr(3'd2, 8'h48);
        while (!scl_oe && guard < 5000) begin @(negedge clk); guard++; end
        while (scl_oe && guard < 5000) begin @(negedge clk); guard++; end
        while (!scl_oe && guard < 5000) begin @(negedge clk); n++; guard++; end
        chk(n == 2 * (p + 1), "R12 SCL high cycles", n, 2 * (p + 1));
        wait_idle(v);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write();
        t_read(8'h33, 8'hC3);
        t_read(8'h34, 8'h01);
        t_nack(8'hEE, -1);
        t_nack(8'hA0, 2);
        t_irq();
        t_badproto();
        t_inuse();
        t_presc(8'd1);
        t_presc(8'd3);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            checks++; errors++;
            $display("FAIL R4 watchdog: cycles %0d expected below %0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule